// File: doc/BRIEF.md
# Round-Robin DMA Channel Scheduler Table

This block tells a multi-channel DMA engine which channel to serve next, and in which direction. Software fills a table of one-byte entries, four of them packed into each 32-bit word. It then writes a control word that holds an enable flag and the index of the last entry in use. While the scheduler is enabled, it presents one entry at a time as a grant: a channel number and a receive/transmit flag. It moves to the following entry each time the engine accepts the grant. After the last entry it returns to entry 0.

The grant interface is a plain valid/ready pair. The register side is a simple 32-bit write port and a read port whose data arrives one cycle later. The usual loading gives each word the pattern transmit c, receive c, transmit c+1, receive c+1, with the last index set to twice the channel count minus one. The block does not enforce this pattern. Any sequence of entries, in any order, is followed as written.

Top module: `rr_sched_table`

## Requirements
- R1: After reset, gnt_valid is 0, reg_rdata is 0, the control word reads 0 and every table word reads 0.
- R2: The control word sits at byte address 0x000. Bit 31 is the enable flag and bits [IDX_W-1:0] hold the last entry index. A read returns both fields, and every other bit reads 0.
- R3: Table word k sits at byte address 0x800 + 4*k, for k below NUM_WORDS. A read of the word returns the value last written to it.
- R4: In an entry byte, bits [CHAN_W-1:0] give gnt_chan and bit 7 gives gnt_rx (1 = receive, 0 = transmit). The bits between CHAN_W and 6 are ignored.
- R5: Entry n is byte lane n mod 4 of word n/4. Lane 0 is bits [7:0], and it is served before lane 1 (bits [15:8]), lane 2 (bits [23:16]) and lane 3 (bits [31:24]).
- R6: The step pointer moves by one entry only in a cycle where both gnt_valid and gnt_ready are 1. While gnt_ready is 0, the grant outputs stay unchanged.
- R7: A grant accepted at an index equal to or above the last entry index is followed by entry 0.
- R8: A control write with bit 31 clear drops gnt_valid in the next cycle and sends the pointer back to entry 0. Enabling the scheduler again therefore starts at entry 0.
- R9: A write to any address other than the control word or an existing table word has no effect. A read of such an address returns 0.
- R10: A table write and an accepted grant may fall in the same cycle. In that case the grant taken in that cycle carries the old entry, and the new value is presented from the next cycle on.
- R11: reg_rdata updates on the clock edge that samples reg_rd, and it holds its value while reg_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Byte address of the write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 12 | Byte address of the read |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| gnt_valid | output | 1 | A grant is being offered |
| gnt_ready | input | 1 | The engine accepts the offered grant |
| gnt_chan | output | CHAN_W | Channel number of the offered grant |
| gnt_rx | output | 1 | 1 = receive grant, 0 = transmit grant |

## Verification
Two things can land in the same cycle: a register write to the table or control word, and a grant handshake that moves the pointer. The bench provokes both. It rewrites the words in use while gnt_ready runs at random, and it clears or shrinks the control word in the middle of a run. A behavioural model then decides, cycle by cycle, which entry must be presented. In that model a handshake uses the entry and limits from before the write, and the write shows from the following cycle on. Every output is compared with the model on every clock.

// File: rtl/sched_pkg.sv
package sched_pkg;

   localparam int REG_W      = 32;
   localparam int LANES      = 4;
   localparam int LANE_W     = 8;
   localparam int RX_BIT     = 7;
   localparam int EN_BIT     = 31;
   localparam int TBL_BASE   = 'h800;

   typedef struct packed {
      logic       rx;
      logic [6:0] chan;
   } sched_entry_t;

   function automatic sched_entry_t entry_of(input logic [LANE_W-1:0] b);
      sched_entry_t e;
      e.rx   = b[RX_BIT];
      e.chan = b[6:0];
      return e;
   endfunction

endpackage

// File: rtl/sched_regs.sv
module sched_regs
   import sched_pkg::*;
#(
   parameter int NUM_WORDS = 64,
   parameter int ADDR_W    = 12,
   localparam int WORD_W   = $clog2(NUM_WORDS),
   localparam int IDX_W    = WORD_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [REG_W-1:0]   rd_data,
   input  logic [WORD_W-1:0]  fetch_idx,
   output logic [REG_W-1:0]   fetch_word,
   output logic               en_o,
   output logic [IDX_W-1:0]   last_o
);

   logic [REG_W-1:0] tbl_q [NUM_WORDS];
   logic             en_q;
   logic [IDX_W-1:0] last_q;

   function automatic logic hits_ctrl(input logic [ADDR_W-1:0] a);
      return a[ADDR_W-1:2] == '0;
   endfunction

   function automatic logic hits_tbl(input logic [ADDR_W-1:0] a);
      return a[ADDR_W-1] && (32'(a[ADDR_W-2:2]) < NUM_WORDS);
   endfunction

   logic wr_ctrl, wr_tbl;
   logic [WORD_W-1:0] wr_word, rd_word;
   assign wr_ctrl = wr_en && hits_ctrl(wr_addr);
   assign wr_tbl  = wr_en && hits_tbl(wr_addr);
   assign wr_word = wr_addr[WORD_W+1:2];
   assign rd_word = rd_addr[WORD_W+1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         last_q <= '0;
      end else if (wr_ctrl) begin
         en_q   <= wr_data[EN_BIT];
         last_q <= wr_data[IDX_W-1:0];
      end
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl_q[w] <= '0;
         else if (wr_tbl && (wr_word == WORD_W'(w)))
            tbl_q[w] <= wr_data;
      end
   end

   logic [REG_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hits_ctrl(rd_addr)) begin
         rd_mux[EN_BIT]      = en_q;
         rd_mux[IDX_W-1:0]   = last_q;
      end else if (hits_tbl(rd_addr)) begin
         rd_mux = tbl_q[rd_word];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end

   assign fetch_word = tbl_q[fetch_idx];
   assign en_o       = en_q;
   assign last_o     = last_q;

   // R9: stray writes leave the control state alone
   a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hits_ctrl(wr_addr)) |=> ($stable(en_q) && $stable(last_q)));

   // R11: read data holds when no read is requested
   a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/sched_stepper.sv
module sched_stepper #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [IDX_W-1:0] last_i,
   input  logic             ready_i,
   output logic [IDX_W-1:0] ptr_o
);

   logic [IDX_W-1:0] ptr_q;
   logic             take;
   logic             at_end;

   assign take   = en_i && ready_i;
   assign at_end = ptr_q >= last_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (!en_i)
         ptr_q <= '0;
      else if (take)
         ptr_q <= at_end ? '0 : ptr_q + 1'b1;
   end

   assign ptr_o = ptr_q;

   // R6: no handshake, no movement
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !ready_i) |=> $stable(ptr_q));

   // R6: a handshake below the end moves by exactly one
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (ptr_q < last_i)) |=> (ptr_q == $past(ptr_q) + 1'b1));

   // R7: a handshake at or past the end returns to entry 0
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (ptr_q >= last_i)) |=> (ptr_q == '0));

endmodule

// File: rtl/sched_lane_sel.sv
module sched_lane_sel
   import sched_pkg::*;
#(
   parameter int CHAN_W = 5
) (
   input  logic [REG_W-1:0]  word_i,
   input  logic [1:0]        lane_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic              rx_o
);

   sched_entry_t ent [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign ent[l] = entry_of(word_i[l*LANE_W +: LANE_W]);
   end

   sched_entry_t pick;
   assign pick   = ent[lane_i];
   assign chan_o = pick.chan[CHAN_W-1:0];
   assign rx_o   = pick.rx;

endmodule

// File: rtl/rr_sched_table.sv
module rr_sched_table
   import sched_pkg::*;
#(
   parameter int NUM_WORDS = 64,
   parameter int CHAN_W    = 5,
   parameter int ADDR_W    = 12,
   localparam int WORD_W   = $clog2(NUM_WORDS),
   localparam int IDX_W    = WORD_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              gnt_valid,
   input  logic              gnt_ready,
   output logic [CHAN_W-1:0] gnt_chan,
   output logic              gnt_rx
);

   if (ADDR_W != 12) begin : g_bad_addr
      $error("rr_sched_table: ADDR_W must be 12");
   end
   if (NUM_WORDS < 2 || NUM_WORDS > 512 || (NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_depth
      $error("rr_sched_table: NUM_WORDS must be a power of two in 2..512");
   end
   if (CHAN_W < 1 || CHAN_W > 7) begin : g_bad_chan
      $error("rr_sched_table: CHAN_W must be 1..7");
   end

   logic             en;
   logic [IDX_W-1:0] last;
   logic [IDX_W-1:0] ptr;
   logic [31:0]      cur_word;

   sched_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_addr    (reg_waddr),
      .wr_data    (reg_wdata),
      .rd_en      (reg_rd),
      .rd_addr    (reg_raddr),
      .rd_data    (reg_rdata),
      .fetch_idx  (ptr[IDX_W-1:2]),
      .fetch_word (cur_word),
      .en_o       (en),
      .last_o     (last)
   );

   sched_stepper #(.IDX_W(IDX_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en),
      .last_i  (last),
      .ready_i (gnt_ready),
      .ptr_o   (ptr)
   );

   sched_lane_sel #(.CHAN_W(CHAN_W)) u_sel (
      .word_i (cur_word),
      .lane_i (ptr[1:0]),
      .chan_o (gnt_chan),
      .rx_o   (gnt_rx)
   );

   assign gnt_valid = en;

   // R8: a control write with the enable clear withdraws the grant
   a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_waddr == '0 && !reg_wdata[EN_BIT]) |=> !gnt_valid);

   // R8: every fresh start of grants begins at entry 0
   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> (ptr == '0));

   // R6: an unaccepted grant keeps its channel and direction unless the table moves
   a_r6_outputs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !gnt_ready && !reg_wr) |=> ($stable(gnt_chan) && $stable(gnt_rx)));

endmodule

// File: tb/sim_rr_sched_table.sv
module sim_rr_sched_table;

   localparam int NUM_WORDS = 64;
   localparam int CHAN_W    = 5;
   localparam int IDX_W     = $clog2(NUM_WORDS) + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [11:0]       reg_waddr = '0;
   logic [31:0]       reg_wdata = '0;
   logic              reg_rd = 1'b0;
   logic [11:0]       reg_raddr = '0;
   logic [31:0]       reg_rdata;
   logic              gnt_valid;
   logic              gnt_ready = 1'b0;
   logic [CHAN_W-1:0] gnt_chan;
   logic              gnt_rx;

   always #5 clk = ~clk;

   rr_sched_table #(.NUM_WORDS(NUM_WORDS), .CHAN_W(CHAN_W)) u0 (.*);

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   int    ready_mode = 0;      // 0 low, 1 high, 2 pseudo-random
   logic [15:0] lfsr = 16'hACE1;
   bit    done = 0;

   // behavioural reference
   logic [31:0] m_tbl [NUM_WORDS];
   bit          m_en;
   int          m_last;
   int          m_ptr;
   logic [31:0] m_rd;

   function automatic logic [31:0] m_read(input logic [11:0] a);
      if (a[11:2] == 0) return {m_en, 23'd0, 8'(m_last)};
      if (a[11] && int'(a[10:2]) < NUM_WORDS) return m_tbl[a[10:2]];
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_tbl[i]) m_tbl[i] = '0;
         m_en = 0; m_last = 0; m_ptr = 0; m_rd = '0;
      end else begin
         if (reg_rd) m_rd = m_read(reg_raddr);
         if (!m_en) m_ptr = 0;
         else if (gnt_ready) m_ptr = (m_ptr >= m_last) ? 0 : m_ptr + 1;
         if (reg_wr) begin
            if (reg_waddr[11:2] == 0) begin
               m_en = reg_wdata[31];
               m_last = int'(reg_wdata[IDX_W-1:0]);
            end else if (reg_waddr[11] && int'(reg_waddr[10:2]) < NUM_WORDS)
               m_tbl[reg_waddr[10:2]] = reg_wdata;
         end
      end
   end

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] b;
         b = 8'(m_tbl[m_ptr >> 2] >> (8 * (m_ptr & 3)));
         check(cur_req, "gnt_valid", 32'(gnt_valid), 32'(m_en));
         check("R11", "reg_rdata", reg_rdata, m_rd);
         if (m_en) begin
            check(cur_req, "gnt_chan (R4/R5)", 32'(gnt_chan), 32'(b[CHAN_W-1:0]));
            check(cur_req, "gnt_rx (R4)", 32'(gnt_rx), 32'(b[7]));
         end
      end
   end

   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gnt_ready <= (ready_mode == 1) || (ready_mode == 2 && lfsr[0]);
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      reg_rd = 1'b1; reg_raddr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      #1 check(req, "register read", reg_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("R1", "reset gnt_valid", 32'(gnt_valid), 32'd0);
      check("R1", "reset reg_rdata", reg_rdata, 32'd0);
      rd_chk(12'h000, 32'd0, "R1");
      rd_chk(12'h804, 32'd0, "R1");

      cur_req = "R3";
      wr(12'h800, 32'h8101_8000);
      wr(12'h804, 32'h8303_8202);
      wr(12'h808, 32'hFF7F_E565);   // R4: bits 6..5 ignored for CHAN_W=5
      wr(12'h8FC, 32'hDEAD_BEEF);
      rd_chk(12'h800, 32'h8101_8000, "R3");
      rd_chk(12'h8FC, 32'hDEAD_BEEF, "R3");

      cur_req = "R2";
      wr(12'h000, 32'h8000_0003);
      rd_chk(12'h000, 32'h8000_0003, "R2");
      wr(12'h000, 32'h8000_00FB);   // bits beyond the index field read 0 only above bit 7
      rd_chk(12'h000, 32'h8000_00FB, "R2");
      wr(12'h000, 32'h0000_0000);
      wr(12'h000, 32'h8000_0007);

      cur_req = "R6";
      ready_mode = 0;
      repeat (8) @(negedge clk);
      check("R6", "held at entry 0 chan", 32'(gnt_chan), 32'd0);

      cur_req = "R5";
      ready_mode = 1;
      repeat (20) @(negedge clk);
      cur_req = "R7";
      ready_mode = 2;
      repeat (40) @(negedge clk);

      cur_req = "R4";
      wr(12'h000, 32'h8000_000B);
      repeat (40) @(negedge clk);

      cur_req = "R8";
      wr(12'h000, 32'h0000_000B);
      #1 check("R8", "grant withdrawn", 32'(gnt_valid), 32'd0);
      repeat (3) @(negedge clk);
      ready_mode = 0;
      wr(12'h000, 32'h8000_0005);
      #1 check("R8", "restart chan", 32'(gnt_chan), 32'd0);
      check("R8", "restart rx", 32'(gnt_rx), 32'd0);
      ready_mode = 2;
      repeat (30) @(negedge clk);

      cur_req = "R10";
      for (int i = 0; i < 24; i++) begin
         wr(12'h800 + 12'(4 * (i % 2)), {lfsr, lfsr ^ 16'h5A5A});
         @(negedge clk);
      end
      ready_mode = 1;
      for (int i = 0; i < 12; i++) wr(12'h804, 32'h8000_0000 | 32'(i));
      wr(12'h000, 32'h8000_0002);   // shrink the window while running
      repeat (20) @(negedge clk);

      cur_req = "R9";
      ready_mode = 0;
      wr(12'h004, 32'h0000_0000);
      wr(12'h400, 32'h1234_5678);
      wr(12'h900, 32'h1111_2222);
      wr(12'hFFC, 32'h3333_4444);
      rd_chk(12'h004, 32'd0, "R9");
      rd_chk(12'h400, 32'd0, "R9");
      rd_chk(12'h900, 32'd0, "R9");
      rd_chk(12'h000, 32'h8000_0002, "R9");
      rd_chk(12'h8FC, 32'hDEAD_BEEF, "R9");
      check("R9", "grant still offered", 32'(gnt_valid), 32'd1);

      cur_req = "R11";
      repeat (5) @(negedge clk);
      check("R11", "read data held", reg_rdata, 32'hDEAD_BEEF);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule